// File: doc/BRIEF.md
# Single-wire bus ROM addressing layer

This block is the addressing stage of a single-wire slave. After every bus reset it takes an 8-bit command from the bit layer and then works out whether the device is selected. It can send its identifier, compare a received identifier, take part in a search of the bus, or select itself with no identifier. A resume flag lets the master select the device again without sending the identifier. An overdrive flag tells the bit layer to use the fast slot timing.

The bit layer sends one strobe per time slot and a strobe per bus reset. A reset strobe comes with a flag that tells whether the reset was long. Before each slot the block sets `txBit` to the level it would drive. A 0 means a pulldown and a 1 means the line is released. At the slot strobe the block samples `rxBit`, which is the resolved wired-AND line level. The identifier is a 64-bit parameter. Bits 7:0 hold the family code, bits 55:8 the serial number and bits 63:56 the check byte. When addressing succeeds, `grant` rises and stays high until the next reset strobe. This hands the bus to the function layer.

Top module: `swire_rom_addr`

## Requirements
- R1: After `rstN` is released, `txBit` is 1, `grant` is 0 and `odFlag` is 0.
- R2: A command is 8 slots long and is taken least significant bit first. Any code other than 33h, 55h, F0h, CCh, A5h, 3Ch or 69h leaves the block silent (`txBit`=1, `grant`=0) until the next reset strobe.
- R3: Code 33h drives the 64 identifier bits on `txBit`, bit 0 first: family code, then serial, then check byte. `grant` rises after the 64th slot.
- R4: Code 55h compares 64 received bits, bit 0 first, with the identifier. A full match raises `grant`. On the first mismatch the block stays silent with `grant`=0 until the next reset strobe.
- R5: Code F0h handles each identifier bit, bit 0 first, as a group of three slots. The block drives the true bit, then its complement, then samples the master's bit. A mismatch drops the block out until reset. Completing all 64 bits raises `grant`.
- R6: Code CCh raises `grant` in the cycle after the 8th command slot.
- R7: The resume flag is set only by a completed 55h, F0h or 69h sequence. Codes 33h, 55h, F0h, CCh, 3Ch and 69h clear it when decoded. Code A5h raises `grant` if the flag is set and otherwise leaves the block silent until reset.
- R8: Code 3Ch sets `odFlag` and raises `grant`.
- R9: Code 69h sets `odFlag` as soon as the command is decoded, before the identifier bits. It then behaves as in R4.
- R10: A reset strobe with `longReset`=1 clears `odFlag`. With `longReset`=0, `odFlag` keeps its value.
- R11: A reset strobe, including one in the middle of a match or search, returns the block to command receive. From the next cycle `grant` is 0 and `txBit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetStrobe | input | 1 | One-cycle pulse: a bus reset was seen |
| longReset | input | 1 | Qualifies `resetStrobe`: the reset was long |
| slotStrobe | input | 1 | One-cycle pulse at the end of a time slot |
| rxBit | input | 1 | Resolved line level in the slot |
| txBit | output | 1 | Level to drive in the coming slot (1 = release) |
| grant | output | 1 | Function layer owns the bus |
| odFlag | output | 1 | Overdrive timing selected |

## Verification
The command table walks several codes through different reset kinds. It separates the commands that grant at once from undefined codes, and separates long resets from short ones by the overdrive flag each leaves behind. Each identifier command is run twice: once with the correct identifier and once with a single bit wrong partway through. This separates a full compare from a partial one. It also shows that the block stays silent after dropping out. Resume is issued after a successful match, a failed match, a search, a read and an overdrive match. The results show which commands set the resume flag and which clear it. A reset in the middle of a match checks that the compare is abandoned.

// File: rtl/swire_rom_pkg.sv
package swire_rom_pkg;
  localparam int CMD_BITS = 8;

  localparam logic [CMD_BITS-1:0] CODE_READ    = 8'h33;
  localparam logic [CMD_BITS-1:0] CODE_MATCH   = 8'h55;
  localparam logic [CMD_BITS-1:0] CODE_SEARCH  = 8'hF0;
  localparam logic [CMD_BITS-1:0] CODE_SKIP    = 8'hCC;
  localparam logic [CMD_BITS-1:0] CODE_RESUME  = 8'hA5;
  localparam logic [CMD_BITS-1:0] CODE_ODSKIP  = 8'h3C;
  localparam logic [CMD_BITS-1:0] CODE_ODMATCH = 8'h69;

  typedef enum logic [2:0] {
    ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_GRANT, ST_QUIET
  } romState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic shiftCmd;
  } dpCtl_t;
endpackage

// File: rtl/swire_rom_datapath.sv
module swire_rom_datapath
  import swire_rom_pkg::*;
#(
  parameter int          ID_BITS = 64,
  parameter logic [63:0] ROM_ID  = 64'hB45A3C96E11F08D1
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic                rxBit,
  output logic [CMD_BITS-1:0] cmdNext,
  output logic                idBit,
  output logic                cntIsLastId,
  output logic                cntIsLastCmd
);
  localparam int CNT_W = $clog2(ID_BITS);

  logic [CNT_W-1:0]    bitCnt;
  logic [CMD_BITS-1:0] cmdReg;

  // LSB-first shift: the newest bit enters at the top
  assign cmdNext      = {rxBit, cmdReg[CMD_BITS-1:1]};
  assign idBit        = ROM_ID[bitCnt];
  assign cntIsLastId  = (bitCnt == CNT_W'(ID_BITS - 1));
  assign cntIsLastCmd = (bitCnt == CNT_W'(CMD_BITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      cmdReg <= '0;
    end else begin
      if (ctl.clrCnt)      bitCnt <= '0;
      else if (ctl.incCnt) bitCnt <= bitCnt + 1'b1;
      if (ctl.shiftCmd)    cmdReg <= cmdNext;
    end
  end
endmodule

// File: rtl/swire_rom_ctrl.sv
module swire_rom_ctrl
  import swire_rom_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                resetStrobe,
  input  logic                longReset,
  input  logic                slotStrobe,
  input  logic                rxBit,
  input  logic [CMD_BITS-1:0] cmdNext,
  input  logic                idBit,
  input  logic                cntIsLastId,
  input  logic                cntIsLastCmd,
  output dpCtl_t              ctl,
  output logic                txBit,
  output logic                grant,
  output logic                odFlag
);
  romState_t state, stateN;
  logic [1:0] phase, phaseN;
  logic       rcFlag, rcN, odN;

  always_comb begin
    stateN = state;
    phaseN = phase;
    rcN    = rcFlag;
    odN    = odFlag;
    ctl    = '0;
    if (resetStrobe) begin
      stateN     = ST_CMD;
      phaseN     = 2'd0;
      ctl.clrCnt = 1'b1;
      if (longReset) odN = 1'b0;
    end else if (slotStrobe) begin
      unique case (state)
        ST_CMD: begin
          ctl.shiftCmd = 1'b1;
          ctl.incCnt   = 1'b1;
          if (cntIsLastCmd) begin
            ctl.clrCnt = 1'b1;
            case (cmdNext)
              CODE_READ:    begin rcN = 1'b0; stateN = ST_READ; end
              CODE_MATCH:   begin rcN = 1'b0; stateN = ST_MATCH; end
              CODE_SEARCH:  begin rcN = 1'b0; stateN = ST_SEARCH; phaseN = 2'd0; end
              CODE_SKIP:    begin rcN = 1'b0; stateN = ST_GRANT; end
              CODE_RESUME:  stateN = rcFlag ? ST_GRANT : ST_QUIET;
              CODE_ODSKIP:  begin rcN = 1'b0; odN = 1'b1; stateN = ST_GRANT; end
              CODE_ODMATCH: begin rcN = 1'b0; odN = 1'b1; stateN = ST_MATCH; end
              default:      stateN = ST_QUIET;
            endcase
          end
        end
        ST_READ: begin
          ctl.incCnt = 1'b1;
          if (cntIsLastId) stateN = ST_GRANT;
        end
        ST_MATCH: begin
          if (rxBit != idBit) stateN = ST_QUIET;
          else begin
            ctl.incCnt = 1'b1;
            if (cntIsLastId) begin rcN = 1'b1; stateN = ST_GRANT; end
          end
        end
        ST_SEARCH: begin
          if (phase != 2'd2) phaseN = phase + 2'd1;
          else begin
            phaseN = 2'd0;
            if (rxBit != idBit) stateN = ST_QUIET;
            else begin
              ctl.incCnt = 1'b1;
              if (cntIsLastId) begin rcN = 1'b1; stateN = ST_GRANT; end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_READ:   txBit = idBit;
      ST_SEARCH: txBit = (phase == 2'd0) ? idBit : (phase == 2'd1) ? !idBit : 1'b1;
      default:   txBit = 1'b1;
    endcase
  end

  assign grant = (state == ST_GRANT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_CMD;
      phase  <= 2'd0;
      rcFlag <= 1'b0;
      odFlag <= 1'b0;
    end else begin
      state  <= stateN;
      phase  <= phaseN;
      rcFlag <= rcN;
      odFlag <= odN;
    end
  end

  assert_reset_silences_R11: assert property (@(posedge clk) disable iff (!rstN)
    resetStrobe |=> (!grant && txBit));

  assert_long_reset_clears_od_R10: assert property (@(posedge clk) disable iff (!rstN)
    (resetStrobe && longReset) |=> !odFlag);

  assert_short_reset_keeps_od_R10: assert property (@(posedge clk) disable iff (!rstN)
    (resetStrobe && !longReset) |=> (odFlag == $past(odFlag)));

  assert_search_complement_R5: assert property (@(posedge clk) disable iff (!rstN)
    (slotStrobe && !resetStrobe && state == ST_SEARCH && phase == 2'd0)
      |=> (txBit == !$past(txBit)));

  assert_resume_flag_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rcFlag) |-> ($past(state) == ST_MATCH || $past(state) == ST_SEARCH));

  assert_grant_follows_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> $past(slotStrobe));
endmodule

// File: rtl/swire_rom_addr.sv
module swire_rom_addr
  import swire_rom_pkg::*;
#(
  parameter int          ID_BITS = 64,
  parameter logic [63:0] ROM_ID  = 64'hB45A3C96E11F08D1
) (
  input  logic clk,
  input  logic rstN,
  input  logic resetStrobe,
  input  logic longReset,
  input  logic slotStrobe,
  input  logic rxBit,
  output logic txBit,
  output logic grant,
  output logic odFlag
);
  dpCtl_t              ctl;
  logic [CMD_BITS-1:0] cmdNext;
  logic                idBit, cntIsLastId, cntIsLastCmd;

  swire_rom_datapath #(.ID_BITS(ID_BITS), .ROM_ID(ROM_ID)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit),
    .cmdNext(cmdNext), .idBit(idBit),
    .cntIsLastId(cntIsLastId), .cntIsLastCmd(cntIsLastCmd)
  );

  swire_rom_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .resetStrobe(resetStrobe), .longReset(longReset),
    .slotStrobe(slotStrobe), .rxBit(rxBit), .cmdNext(cmdNext), .idBit(idBit),
    .cntIsLastId(cntIsLastId), .cntIsLastCmd(cntIsLastCmd),
    .ctl(ctl), .txBit(txBit), .grant(grant), .odFlag(odFlag)
  );
endmodule

// File: tb/swire_rom_addr_tb.sv
`timescale 1ns/1ps
module swire_rom_addr_tb;
  localparam logic [63:0] ID = 64'hB45A3C96E11F08D1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetStrobe = 1'b0, longReset = 1'b0, slotStrobe = 1'b0, rxBit = 1'b1;
  logic txBit, grant, odFlag;
  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  swire_rom_addr #(.ID_BITS(64), .ROM_ID(ID)) u_dut (
    .clk(clk), .rstN(rstN), .resetStrobe(resetStrobe), .longReset(longReset),
    .slotStrobe(slotStrobe), .rxBit(rxBit),
    .txBit(txBit), .grant(grant), .odFlag(odFlag)
  );

  // {longReset, command code, expected grant, expected odFlag}
  localparam logic [10:0] VEC [0:5] = '{
    {1'b1, 8'hCC, 1'b1, 1'b0},  // R6 skip
    {1'b1, 8'h3C, 1'b1, 1'b1},  // R8 overdrive skip
    {1'b0, 8'hCC, 1'b1, 1'b1},  // R10 short reset keeps overdrive
    {1'b1, 8'hA5, 1'b0, 1'b0},  // R7 resume with flag clear
    {1'b1, 8'h00, 1'b0, 1'b0},  // R2 undefined code
    {1'b1, 8'h96, 1'b0, 1'b0}   // R2 undefined code
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic m, output logic obs);
    @(negedge clk);
    obs = txBit;
    rxBit = m & txBit;
    slotStrobe = 1'b1;
    @(negedge clk);
    slotStrobe = 1'b0;
    rxBit = 1'b1;
  endtask

  task automatic busReset(input logic isLong);
    @(negedge clk);
    resetStrobe = 1'b1;
    longReset = isLong;
    @(negedge clk);
    resetStrobe = 1'b0;
    longReset = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    logic o;
    for (int i = 0; i < 8; i++) slot(b[i], o);
  endtask

  // sends identifier, with bit flipIdx inverted (-1: none); returns AND of observed txBit
  task automatic sendId(input int flipIdx, output logic allHigh);
    logic o;
    allHigh = 1'b1;
    for (int i = 0; i < 64; i++) begin
      slot((i == flipIdx) ? !ID[i] : ID[i], o);
      allHigh &= o;
    end
  endtask

  // search pass; returns count of bad true/complement pairs and AND of txBit after dropout
  task automatic searchId(input int flipIdx, output int badPairs, output logic silentAfter);
    logic o0, o1, ox;
    badPairs = 0;
    silentAfter = 1'b1;
    for (int i = 0; i < 64; i++) begin
      slot(1'b1, o0);
      slot(1'b1, o1);
      if (flipIdx < 0 || i <= flipIdx)
        if (o0 !== ID[i] || o1 !== !ID[i]) badPairs++;
      if (flipIdx >= 0 && i > flipIdx) silentAfter &= (o0 & o1);
      slot((i == flipIdx) ? !ID[i] : ID[i], ox);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic o, hi;
    logic [63:0] rd;
    int bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txBit === 1'b1 && grant === 1'b0 && odFlag === 1'b0, "R1 reset state",
          {txBit, grant, odFlag}, 3'b100);

    foreach (VEC[k]) begin
      busReset(VEC[k][10]);
      sendByte(VEC[k][9:2]);
      check(grant === VEC[k][1], "R2/R6/R7/R8 table grant", grant, VEC[k][1]);
      check(odFlag === VEC[k][0], "R8/R10 table overdrive", odFlag, VEC[k][0]);
    end

    // R3 read identifier
    busReset(1'b1);
    sendByte(8'h33);
    for (int i = 0; i < 64; i++) begin slot(1'b1, o); rd[i] = o; end
    check(rd === ID, "R3 read bits", rd, ID);
    check(grant === 1'b1, "R3 grant after read", grant, 1);

    // R4 good match, then R7 resume
    busReset(1'b1);
    sendByte(8'h55);
    sendId(-1, hi);
    check(grant === 1'b1, "R4 full match grant", grant, 1);
    busReset(1'b1);
    sendByte(8'hA5);
    check(grant === 1'b1, "R7 resume after match", grant, 1);

    // R4 bad match, R7 match clears flag
    busReset(1'b1);
    sendByte(8'h55);
    sendId(20, hi);
    check(grant === 1'b0 && hi === 1'b1, "R4 mismatch silent", {grant, hi}, 2'b01);
    busReset(1'b1);
    sendByte(8'hA5);
    check(grant === 1'b0, "R7 resume after failed match", grant, 0);

    // R5 full search, resume
    busReset(1'b1);
    sendByte(8'hF0);
    searchId(-1, bad, hi);
    check(bad == 0, "R5 search triplets", bad, 0);
    check(grant === 1'b1, "R5 search complete grant", grant, 1);
    busReset(1'b1);
    sendByte(8'hA5);
    check(grant === 1'b1, "R7 resume after search", grant, 1);

    // R7 read clears resume flag
    busReset(1'b1);
    sendByte(8'h33);
    for (int i = 0; i < 64; i++) slot(1'b1, o);
    busReset(1'b1);
    sendByte(8'hA5);
    check(grant === 1'b0, "R7 resume after read", grant, 0);

    // R5 search dropout
    busReset(1'b1);
    sendByte(8'hF0);
    searchId(5, bad, hi);
    check(bad == 0 && hi === 1'b1, "R5 search dropout silent", {bad[0], hi}, 2'b01);
    check(grant === 1'b0, "R5 search dropout no grant", grant, 0);

    // R9 overdrive match, R10 reset kinds
    busReset(1'b1);
    sendByte(8'h69);
    check(odFlag === 1'b1 && grant === 1'b0, "R9 overdrive before id", {odFlag, grant}, 2'b10);
    sendId(-1, hi);
    check(grant === 1'b1, "R9 overdrive match grant", grant, 1);
    busReset(1'b0);
    sendByte(8'hA5);
    check(grant === 1'b1 && odFlag === 1'b1, "R10 short reset keeps od, R7 resume",
          {grant, odFlag}, 2'b11);
    busReset(1'b1);
    check(odFlag === 1'b0, "R10 long reset clears od", odFlag, 0);

    // R11 abort in-progress match
    busReset(1'b1);
    sendByte(8'h55);
    for (int i = 0; i < 10; i++) slot(ID[i], o);
    busReset(1'b0);
    check(grant === 1'b0 && txBit === 1'b1, "R11 abort state", {grant, txBit}, 2'b01);
    sendByte(8'hCC);
    check(grant === 1'b1, "R11 command after abort", grant, 1);

    // R2 undefined code stays silent over further slots
    busReset(1'b1);
    sendByte(8'h12);
    hi = 1'b1;
    for (int i = 0; i < 16; i++) begin slot(1'b0, o); hi &= o; end
    check(hi === 1'b1 && grant === 1'b0, "R2 undefined code silent", {hi, grant}, 2'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule